// File: doc/BRIEF.md
# Speculative Alias Check Tracker

This block keeps per-line speculation marks for a core running inside an atomic region, so that compiled code which has moved loads up or stores down past possibly aliasing accesses can be checked in hardware. Each line touched inside a region may hold a read mark, a write mark, or both. The read mark is set and cleared only by dedicated instructions. The write mark is set by every store, because the checkpoint needs the region's full write set.

A stream of memory operations arrives with a valid strobe, a kind code and a byte address. Checked stores test the marks of their line and either pass or abort the region. Region begin, commit and abort commands arrive on a separate command input. Begin captures the PC of the unoptimised safe code. Any abort flushes all marks and emits a one-cycle redirect to that PC, together with a cause code. The marks are held in a small fully associative table of line tags. A slot is free whenever both of its marks are clear.

Top module: `alias_track`

## Requirements
- R1: Lines are 64 bytes. Two addresses that differ only in bits [5:0] select the same tracked line.
- R2: A marked load (op kind 1) sets the read mark of its line. A plain load (kind 0) never creates or changes a mark, so a later read-checked store to that line passes.
- R3: A mark clear (kind 2) clears the read mark of its line and keeps that line's write mark.
- R4: Every store kind (3 plain, 4 read-checked, 5 write-checked, 6 both-checked) that does not abort sets the write mark of its line while a region is active.
- R5: Checked stores assert chk_valid_o one cycle after they are presented. Kind 4 aborts when the read mark is set. Kind 5 aborts when the write mark is set. Kind 6 aborts when either mark is set. The cause is 1 if the read mark triggered the abort, which takes priority, and 2 if the write mark did.
- R6: A checked store is tested against the marks as they stood before its own write mark is set, so a write-checked store to an untouched line passes.
- R7: Begin (command 1) while idle captures rgn_pc_i. Every abort drops active_o and pulses redirect_valid_o high for exactly one cycle, one cycle after the cause, with redirect_pc_o equal to the captured PC.
- R8: Commit (command 2) clears every mark and makes the block idle without a redirect.
- R9: If an operation needs a new slot (marked load or any store) and all ENTRIES slots hold a mark, the region aborts with cause 3. A slot whose marks are both cleared becomes free again.
- R10: While idle, operations change no mark and checked stores never abort.
- R11: Abort (command 3) in an active region clears every mark and reports cause 0.
- R12: An operation presented in the same cycle as a nonzero command has no effect on the marks. Begin while active, and commit or abort while idle, are ignored.
- R13: After reset the block is idle, with no redirect, no check result and cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rgn_cmd_i | input | 2 | Region command: 0 none, 1 begin, 2 commit, 3 abort |
| rgn_pc_i | input | PC_W | Safe-code PC sampled on begin |
| op_valid_i | input | 1 | Memory operation present |
| op_kind_i | input | 3 | Operation kind, codes as in R2 to R4; 7 is a no-op |
| op_addr_i | input | ADDR_W | Byte address of the operation |
| active_o | output | 1 | Region active |
| chk_valid_o | output | 1 | Result of a checked store is valid |
| chk_abort_o | output | 1 | The checked store aborted the region |
| redirect_valid_o | output | 1 | One-cycle redirect after an abort |
| redirect_pc_o | output | PC_W | Captured safe-code PC |
| cause_o | output | 2 | Cause of the last abort |

## Verification
The assertions assume that rgn_cmd_i and op_kind_i carry only the listed codes, and that the core never relies on an operation sent in the same cycle as a command. The stimulus draws kinds from 0 to 6 and commands from 0 to 3. Addresses come from a pool of twelve lines with random byte offsets, so with eight slots the table both aliases and overflows often. A bench model predicts every result, and directed sequences cover the priority cases and the same-cycle cases.

// File: rtl/alias_pkg.sv
package alias_pkg;
  typedef enum logic [2:0] {
    OP_LD        = 3'd0,
    OP_LD_MARK   = 3'd1,
    OP_CLR_MARK  = 3'd2,
    OP_ST        = 3'd3,
    OP_ST_CHK_R  = 3'd4,
    OP_ST_CHK_W  = 3'd5,
    OP_ST_CHK_RW = 3'd6,
    OP_NOP       = 3'd7
  } op_kind_e;

  typedef enum logic [1:0] {
    RC_NONE   = 2'd0,
    RC_BEGIN  = 2'd1,
    RC_COMMIT = 2'd2,
    RC_ABORT  = 2'd3
  } rgn_cmd_e;

  localparam logic [1:0] CAUSE_EXPLICIT = 2'd0;
  localparam logic [1:0] CAUSE_RD_ALIAS = 2'd1;
  localparam logic [1:0] CAUSE_WR_ALIAS = 2'd2;
  localparam logic [1:0] CAUSE_FULL     = 2'd3;
endpackage

// File: rtl/alias_tag_table.sv
module alias_tag_table #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             wr_en_i,
  input  logic             set_sr_i,
  input  logic             clr_sr_i,
  input  logic             set_sw_i,
  input  logic             flush_i,
  output logic             hit_o,
  output logic             hit_sr_o,
  output logic             hit_sw_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] sr_q, sw_q, live, hit_vec;
  logic [IDX_W-1:0]   hit_idx, free_idx;

  assign live = sr_q | sw_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = live[g] && (tag_q[g] == tag_i);
  end

  // lowest matching and lowest free slot
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (!live[i])   free_idx = IDX_W'(i);
    end
  end

  assign hit_o    = |hit_vec;
  assign hit_sr_o = |(hit_vec & sr_q);
  assign hit_sw_o = |(hit_vec & sw_q);
  assign full_o   = &live;
  assign empty_o  = ~|live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      sw_q <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else if (flush_i) begin
      sr_q <= '0;
      sw_q <= '0;
    end else if (wr_en_i) begin
      if (hit_o) begin
        sr_q[hit_idx] <= (sr_q[hit_idx] | set_sr_i) & ~clr_sr_i;
        sw_q[hit_idx] <= sw_q[hit_idx] | set_sw_i;
      end else if (!full_o && (set_sr_i || set_sw_i)) begin
        tag_q[free_idx] <= tag_i;
        sr_q[free_idx]  <= set_sr_i;
        sw_q[free_idx]  <= set_sw_i;
      end
    end
  end

  a_r1_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  a_r9_no_alloc_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i && !hit_o && full_o) |=> $stable(live));
endmodule

// File: rtl/alias_chk.sv
module alias_chk
  import alias_pkg::*;
(
  input  logic       active_i,
  input  logic       op_valid_i,
  input  logic [2:0] op_kind_i,
  input  logic       cmd_busy_i,
  input  logic       hit_i,
  input  logic       hit_sr_i,
  input  logic       hit_sw_i,
  input  logic       full_i,
  output logic       tbl_wr_o,
  output logic       set_sr_o,
  output logic       clr_sr_o,
  output logic       set_sw_o,
  output logic       chk_req_o,
  output logic       abort_o,
  output logic [1:0] cause_o
);
  op_kind_e kind;
  logic is_chk, is_store, need_slot, track, ovf, alias_r, alias_w;

  assign kind      = op_kind_e'(op_kind_i);
  assign is_chk    = kind inside {OP_ST_CHK_R, OP_ST_CHK_W, OP_ST_CHK_RW};
  assign is_store  = is_chk || (kind == OP_ST);
  assign need_slot = is_store || (kind == OP_LD_MARK);
  assign track     = op_valid_i && !cmd_busy_i && active_i;

  // marks are read before this store's own write mark lands
  assign ovf     = track && need_slot && !hit_i && full_i;
  assign alias_r = track && (kind inside {OP_ST_CHK_R, OP_ST_CHK_RW}) && hit_sr_i;
  assign alias_w = track && (kind inside {OP_ST_CHK_W, OP_ST_CHK_RW}) && hit_sw_i;

  assign abort_o   = ovf || alias_r || alias_w;
  assign cause_o   = ovf ? CAUSE_FULL : (alias_r ? CAUSE_RD_ALIAS : CAUSE_WR_ALIAS);
  assign tbl_wr_o  = track && !abort_o;
  assign set_sr_o  = (kind == OP_LD_MARK);
  assign clr_sr_o  = (kind == OP_CLR_MARK);
  assign set_sw_o  = is_store;
  assign chk_req_o = op_valid_i && is_chk;
endmodule

// File: rtl/alias_region_ctl.sv
module alias_region_ctl
  import alias_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      rgn_cmd_i,
  input  logic [PC_W-1:0] rgn_pc_i,
  input  logic            chk_req_i,
  input  logic            op_abort_i,
  input  logic [1:0]      op_cause_i,
  output logic            flush_o,
  output logic            active_o,
  output logic            chk_valid_o,
  output logic            chk_abort_o,
  output logic            redirect_valid_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [1:0]      cause_o
);
  rgn_cmd_e cmd;
  logic begin_ok, commit_ok, xabort;

  assign cmd       = rgn_cmd_e'(rgn_cmd_i);
  assign begin_ok  = (cmd == RC_BEGIN)  && !active_o;
  assign commit_ok = (cmd == RC_COMMIT) && active_o;
  assign xabort    = (cmd == RC_ABORT)  && active_o;
  assign flush_o   = commit_ok || xabort || op_abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o         <= 1'b0;
      chk_valid_o      <= 1'b0;
      chk_abort_o      <= 1'b0;
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
      cause_o          <= CAUSE_EXPLICIT;
    end else begin
      if (begin_ok) begin
        active_o      <= 1'b1;
        redirect_pc_o <= rgn_pc_i;
      end else if (flush_o) begin
        active_o <= 1'b0;
      end
      if (xabort)          cause_o <= CAUSE_EXPLICIT;
      else if (op_abort_i) cause_o <= op_cause_i;
      redirect_valid_o <= xabort || op_abort_i;
      chk_valid_o      <= chk_req_i;
      chk_abort_o      <= chk_req_i && op_abort_i;
    end
  end

  a_r7_redirect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> !active_o);
  a_r7_pc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o)) |-> $stable(redirect_pc_o));
  a_r5_abort_reported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_abort_o |-> (chk_valid_o && redirect_valid_o));
  a_r11_explicit_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xabort |=> (redirect_valid_o && cause_o == CAUSE_EXPLICIT));
  a_r12_cmd_op_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xabort && op_abort_i));
endmodule

// File: rtl/alias_track.sv
module alias_track
  import alias_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int ENTRIES    = 8,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rgn_cmd_i,
  input  logic [PC_W-1:0]   rgn_pc_i,
  input  logic              op_valid_i,
  input  logic [2:0]        op_kind_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  output logic              active_o,
  output logic              chk_valid_o,
  output logic              chk_abort_o,
  output logic              redirect_valid_o,
  output logic [PC_W-1:0]   redirect_pc_o,
  output logic [1:0]        cause_o
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0] tag;
  logic unused_ofs;
  logic hit, hit_sr, hit_sw, full, empty;
  logic tbl_wr, set_sr, clr_sr, set_sw, flush;
  logic chk_req, op_abort;
  logic [1:0] op_cause;

  assign tag        = op_addr_i[ADDR_W-1:OFS_W];
  assign unused_ofs = ^op_addr_i[OFS_W-1:0];

  alias_tag_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tbl (
    .clk_i, .rst_ni, .tag_i(tag), .wr_en_i(tbl_wr), .set_sr_i(set_sr),
    .clr_sr_i(clr_sr), .set_sw_i(set_sw), .flush_i(flush),
    .hit_o(hit), .hit_sr_o(hit_sr), .hit_sw_o(hit_sw), .full_o(full), .empty_o(empty)
  );

  alias_chk u_chk (
    .active_i(active_o), .op_valid_i, .op_kind_i, .cmd_busy_i(rgn_cmd_i != RC_NONE),
    .hit_i(hit), .hit_sr_i(hit_sr), .hit_sw_i(hit_sw), .full_i(full),
    .tbl_wr_o(tbl_wr), .set_sr_o(set_sr), .clr_sr_o(clr_sr), .set_sw_o(set_sw),
    .chk_req_o(chk_req), .abort_o(op_abort), .cause_o(op_cause)
  );

  alias_region_ctl #(.PC_W(PC_W)) u_ctl (
    .clk_i, .rst_ni, .rgn_cmd_i, .rgn_pc_i, .chk_req_i(chk_req),
    .op_abort_i(op_abort), .op_cause_i(op_cause), .flush_o(flush),
    .active_o, .chk_valid_o, .chk_abort_o, .redirect_valid_o, .redirect_pc_o, .cause_o
  );

  a_r10_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> empty);
  a_r10_idle_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !op_abort);
endmodule

// File: tb/sim_alias_track.sv
module sim_alias_track;
  localparam int ENT = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rgn_cmd = 2'd0;
  logic [31:0] rgn_pc = '0, op_addr = '0, redir_pc;
  logic op_valid = 1'b0;
  logic [2:0] op_kind = '0;
  logic active, chkv, chka, redir;
  logic [1:0] cause;

  alias_track u0 (
    .clk_i(clk), .rst_ni(rst_n), .rgn_cmd_i(rgn_cmd), .rgn_pc_i(rgn_pc),
    .op_valid_i(op_valid), .op_kind_i(op_kind), .op_addr_i(op_addr),
    .active_o(active), .chk_valid_o(chkv), .chk_abort_o(chka),
    .redirect_valid_o(redir), .redirect_pc_o(redir_pc), .cause_o(cause)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [25:0] m_tag [ENT];
  bit m_sr [ENT], m_sw [ENT];
  bit m_act = 0;
  logic [31:0] m_pc = '0;
  logic [1:0] m_cause = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic flush_model();
    for (int i = 0; i < ENT; i++) begin m_sr[i] = 0; m_sw[i] = 0; end
  endtask

  // kind < 0 means no operation; cmd 0 none, 1 begin, 2 commit, 3 abort
  task automatic step(input int kind, input logic [31:0] addr, input int cmd,
                      input logic [31:0] pc, input string req);
    bit ev = (kind >= 0);
    bit is_chk = ev && kind >= 4 && kind <= 6;
    bit ab = 0, exp_redir = 0;
    if (cmd == 1) begin
      if (!m_act) begin m_act = 1; m_pc = pc; end
    end else if (cmd == 2) begin
      if (m_act) begin flush_model(); m_act = 0; end
    end else if (cmd == 3) begin
      if (m_act) begin flush_model(); m_act = 0; m_cause = 0; exp_redir = 1; end
    end else if (ev && m_act) begin
      logic [25:0] tg = addr[31:6];
      int hit = -1, live = 0;
      bit hsr, hsw, alloc;
      for (int i = 0; i < ENT; i++)
        if (m_sr[i] || m_sw[i]) begin live++; if (m_tag[i] == tg) hit = i; end
      hsr = (hit >= 0) && m_sr[hit];
      hsw = (hit >= 0) && m_sw[hit];
      alloc = (kind == 1) || (kind >= 3 && kind <= 6);
      if (alloc && hit < 0 && live == ENT) begin ab = 1; m_cause = 3; end
      else if ((kind == 4 || kind == 6) && hsr) begin ab = 1; m_cause = 1; end
      else if ((kind == 5 || kind == 6) && hsw) begin ab = 1; m_cause = 2; end
      if (ab) begin flush_model(); m_act = 0; exp_redir = 1; end
      else if (hit >= 0) begin
        if (kind == 1) m_sr[hit] = 1;
        if (kind == 2) m_sr[hit] = 0;
        if (kind >= 3 && kind <= 6) m_sw[hit] = 1;
      end else if (alloc) begin
        for (int i = 0; i < ENT; i++)
          if (!(m_sr[i] || m_sw[i])) begin
            m_tag[i] = tg; m_sr[i] = (kind == 1); m_sw[i] = (kind != 1);
            break;
          end
      end
    end
    @(negedge clk);
    op_valid = ev; op_kind = ev ? kind[2:0] : 3'd0; op_addr = addr;
    rgn_cmd = cmd[1:0]; rgn_pc = pc;
    @(posedge clk); #1;
    check({req, " chk_valid"}, {31'd0, chkv}, {31'd0, is_chk});
    check({req, " chk_abort"}, {31'd0, chka}, {31'd0, is_chk && ab});
    check({req, " redirect"}, {31'd0, redir}, {31'd0, exp_redir});
    check({req, " active"}, {31'd0, active}, {31'd0, m_act});
    if (exp_redir) begin
      check({req, " cause"}, {30'd0, cause}, {30'd0, m_cause});
      check({req, " pc"}, redir_pc, m_pc);
    end
    @(negedge clk);
    op_valid = 0; rgn_cmd = 0;
  endtask

  function automatic string req_of(input int kind);
    case (kind)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  localparam logic [31:0] A = 32'h0000_1000, B = 32'h0000_2040;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    flush_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R13 active", {31'd0, active}, 0);
    check("R13 redirect", {31'd0, redir}, 0);
    check("R13 chk_valid", {31'd0, chkv}, 0);
    check("R13 cause", {30'd0, cause}, 0);

    step(6, A, 0, 0, "R10 idle chk");
    step(1, A, 0, 0, "R10 idle mark");
    step(-1, 0, 1, 32'hBEEF0, "R7 begin");
    step(4, A, 0, 0, "R10 no mark from idle");
    step(1, A + 4, 0, 0, "R1 mark");
    step(4, A + 60, 0, 0, "R1 same line abort");
    @(posedge clk); #1;
    check("R7 redirect one shot", {31'd0, redir}, 0);

    step(-1, 0, 1, 32'h100, "R7 begin");
    step(0, A, 0, 0, "R2 plain load");
    step(4, A, 0, 0, "R2 plain load no mark");
    step(3, A + 8, 0, 0, "R4 store");
    step(5, A, 0, 0, "R4 write mark abort");

    step(-1, 0, 1, 32'h200, "R7 begin");
    step(1, A, 0, 0, "R3 mark");
    step(3, A, 0, 0, "R3 store");
    step(2, A, 0, 0, "R3 clear");
    step(4, A, 0, 0, "R3 read cleared");
    step(5, A, 0, 0, "R3 write kept");

    step(-1, 0, 1, 32'h300, "R7 begin");
    step(5, B, 0, 0, "R6 self pass");
    step(6, B, 0, 0, "R6 second aborts");

    step(-1, 0, 1, 32'h400, "R7 begin");
    step(1, A, 0, 0, "R5 mark");
    step(3, A, 0, 0, "R5 store");
    step(6, A, 0, 0, "R5 read priority");

    step(-1, 0, 1, 32'h500, "R7 begin");
    step(1, A, 0, 0, "R8 mark");
    step(-1, 0, 2, 0, "R8 commit");
    step(-1, 0, 1, 32'h600, "R8 begin");
    step(6, A, 0, 0, "R8 marks cleared");
    step(-1, 0, 2, 0, "R8 commit");

    step(-1, 0, 1, 32'h700, "R12 begin");
    step(-1, 0, 1, 32'h800, "R12 rebegin ignored");
    step(-1, 0, 3, 0, "R11 explicit abort");
    step(-1, 0, 3, 0, "R12 idle abort ignored");
    step(-1, 0, 2, 0, "R12 idle commit ignored");

    step(-1, 0, 1, 32'h900, "R9 begin");
    for (int i = 0; i < ENT; i++) step(1, A + i * 64, 0, 0, "R9 fill");
    step(1, A + ENT * 64, 0, 0, "R9 overflow");
    step(-1, 0, 1, 32'hA00, "R9 begin");
    for (int i = 0; i < ENT; i++) step(1, A + i * 64, 0, 0, "R9 fill");
    step(2, A + 3 * 64, 0, 0, "R9 free slot");
    step(1, A + ENT * 64, 0, 0, "R9 reuse");
    step(3, A + (ENT + 1) * 64, 0, 0, "R9 store overflow");

    step(-1, 0, 1, 32'hB00, "R12 begin");
    step(1, A, 2, 0, "R12 op with commit");
    step(-1, 0, 1, 32'hC00, "R12 begin");
    step(1, A, 3, 0, "R12 op with abort");
    step(-1, 0, 1, 32'hD00, "R12 begin");
    step(4, A, 0, 0, "R12 op had no effect");

    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 100);
      logic [31:0] ad = A + ($urandom % 12) * 64 + ($urandom % 64);
      if (r < 4) step(-1, 0, 1, $urandom, "R7 rnd begin");
      else if (r < 6) step(-1, 0, 2, 0, "R8 rnd commit");
      else if (r < 7) step(-1, 0, 3, 0, "R11 rnd abort");
      else begin
        int k = int'($urandom % 7);
        step(k, ad, 0, 0, req_of(k));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule